// File: doc/BRIEF.md
# RAW10 Pixel Repacker

This block is a streaming converter placed between the read side and the write side of a memory-to-memory copy path. It takes a byte stream in and gives a byte stream out. Each line is set up by a mode, a bit offset and a pixel count, and then launched with a one-cycle start pulse. Pass-through mode copies bytes unchanged. Pack mode takes 10-bit pixels held in 16-bit little-endian containers and squeezes them into a gap-free 10-bit bitstream. Spread mode does the reverse: it reads a gap-free 10-bit bitstream and writes each pixel into its own zero-padded 16-bit container, at a selectable bit offset.

Both edges of the block use valid/ready handshakes. Before a line starts, the block checks the lowest address bit of the source and of the destination against the rules for the chosen mode. A violation raises a sticky error instead of starting the line. Address generation and bus transactions belong to the surrounding copy engine.

Top module: `raw10_repack`

## Requirements
- R1: With mode code 0, a line of `line_pix` input bytes is copied to the output unchanged and in order, and `out_last` is high only on the final byte.
- R2: With mode code 1, each pixel arrives as two bytes, low byte first. The pixel is bits [9:0] of that 16-bit container, and bits [15:10] have no effect on the output.
- R3: With mode code 1, pixels are written least-significant bit first, back to back with no gaps. Pixel k occupies stream bits 10k to 10k+9, so four pixels make exactly five output bytes.
- R4: With mode code 1, a line emits ceil(10*line_pix/8) bytes. Unused bits of the final byte are zero, and `out_last` marks that byte.
- R5: With mode code 2, the block consumes ceil(10*line_pix/8) input bytes holding a least-significant-bit-first 10-bit stream. For each pixel it emits two bytes, low byte first, of a 16-bit word that holds the pixel at bit 2*`bit_ofs` and zeros elsewhere. `out_last` marks the second byte of the final pixel.
- R6: Leftover bits from one line, including padding bits in the last input byte of a spread line, never reach the next line: every line starts at stream bit 0.
- R7: At start, pack mode with `src_lsb`=1, or spread mode with `dst_lsb`=1, sets `align_err` and leaves `busy` low. Pass-through mode and code 3 accept any alignment.
- R8: `align_err` stays set until `err_clr` is pulsed. While it is set, a start pulse is ignored even if the configuration is aligned.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R10: `in_ready` is low whenever no line is active. A start pulse while a line is active has no effect, and mode code 3 behaves as pass-through.
- R11: A line with `line_pix`=0 finishes with no output and no input consumed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that launches a line |
| mode | input | 2 | 0 pass-through, 1 pack, 2 spread, 3 pass-through |
| bit_ofs | input | 2 | Spread mode: pixel placed at bit 2*bit_ofs |
| line_pix | input | CNT_W | Pixels per line (bytes in pass-through mode) |
| src_lsb | input | 1 | Bit 0 of the source address |
| dst_lsb | input | 1 | Bit 0 of the destination address |
| err_clr | input | 1 | Clears the alignment error |
| busy | output | 1 | A line is active |
| align_err | output | 1 | Sticky alignment error |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Input byte accepted when valid |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the line |
| out_ready | input | 1 | Downstream accepts the output byte |

## Verification
The pixel sets include all-ones and all-zeros pixels next to each other, so a pack or spread that shifts by the wrong amount, or takes the wrong end of a byte, lands on a visibly different byte. Pack lines use four pixels, where the stream ends on a byte boundary, and odd counts, where a zero-filled tail byte is needed. The pack inputs carry random junk in the upper six container bits to show those bits are dropped. Spread lines are run at all four offsets with the padding bits of the last input byte set to one, and each is followed by a second line, which shows whether leftover bits leak across the line boundary. Random output stalls and input gaps separate a correct backpressure path from one that loses or repeats bytes.

// File: rtl/raw10_pkg.sv
package raw10_pkg;
    localparam int PIX_W  = 10;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        MODE_PASS   = 2'd0,
        MODE_PACK   = 2'd1,
        MODE_SPREAD = 2'd2,
        MODE_RSVD   = 2'd3
    } mode_e;
endpackage

// File: rtl/raw10_launch.sv
module raw10_launch
    import raw10_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    input  mode_e mode,
    input  logic  src_lsb,
    input  logic  dst_lsb,
    input  logic  err_clr,
    input  logic  core_busy,
    output logic  launch,
    output logic  align_err
);
    typedef struct packed {
        logic err;
    } gate_t;

    gate_t gate_d, gate_q;
    logic  misaligned;

    always_comb begin
        // Pack reads 16-bit containers; spread writes them.
        case (mode)
            MODE_PACK:   misaligned = src_lsb;
            MODE_SPREAD: misaligned = dst_lsb;
            default:     misaligned = 1'b0;
        endcase

        gate_d = gate_q;
        launch = 1'b0;
        if (err_clr) begin
            gate_d.err = 1'b0;
        end
        if (start && !core_busy && !gate_q.err) begin
            if (misaligned) begin
                gate_d.err = 1'b1;
            end else begin
                launch = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= '0;
        end else begin
            gate_q <= gate_d;
        end
    end

    assign align_err = gate_q.err;
endmodule

// File: rtl/raw10_len_calc.sv
module raw10_len_calc
    import raw10_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int REM_W = CNT_W + 1
) (
    input  mode_e             mode,
    input  logic [CNT_W-1:0]  pix,
    output logic [REM_W-1:0]  in_len
);
    localparam int WIDE_W = CNT_W + 4;
    localparam int BSH    = $clog2(BYTE_W);

    logic [WIDE_W-1:0] bits_w;
    logic [WIDE_W-1:0] bytes_w;

    always_comb begin
        bits_w  = WIDE_W'(pix) * WIDE_W'(PIX_W);
        bytes_w = (bits_w + WIDE_W'(BYTE_W - 1)) >> BSH;
        case (mode)
            MODE_PACK:   in_len = {pix, 1'b0};
            MODE_SPREAD: in_len = REM_W'(bytes_w);
            default:     in_len = REM_W'(pix);
        endcase
    end
endmodule

// File: rtl/raw10_repack_core.sv
module raw10_repack_core
    import raw10_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int REM_W = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  mode_e             launch_mode,
    input  logic [1:0]        launch_ofs,
    input  logic [CNT_W-1:0]  launch_pix,
    input  logic [REM_W-1:0]  launch_len,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_last,
    input  logic              out_ready,
    output logic              busy
);
    localparam int ACC_W = 3 * BYTE_W;
    localparam int NB_W  = $clog2(ACC_W + 1);

    typedef struct packed {
        logic              busy;
        mode_e             mode;
        logic [1:0]        ofs;
        logic [REM_W-1:0]  in_rem;
        logic [CNT_W-1:0]  pix_rem;
        logic [ACC_W-1:0]  acc;
        logic [NB_W-1:0]   nbits;
        logic              half;
        logic [BYTE_W-1:0] lo;
        logic              phase;
    } core_t;

    core_t s_d, s_q;

    logic [WORD_W-1:0] word;
    logic              ov, ol, ir, fire_out, fire_in;
    logic [BYTE_W-1:0] od;
    logic [ACC_W-1:0]  acc_a;
    logic [NB_W-1:0]   nb_a;
    logic [PIX_W-1:0]  pix_new;

    always_comb begin
        s_d  = s_q;
        word = WORD_W'(s_q.acc[PIX_W-1:0]) << {s_q.ofs, 1'b0};
        od   = s_q.acc[BYTE_W-1:0];
        ov   = 1'b0;
        ol   = 1'b0;

        // Output side, driven only from registered state
        case (s_q.mode)
            MODE_PACK: begin
                ov = s_q.busy && (s_q.nbits >= NB_W'(BYTE_W) ||
                                  (s_q.in_rem == '0 && s_q.nbits != '0));
                ol = (s_q.in_rem == '0) && (s_q.nbits <= NB_W'(BYTE_W));
            end
            MODE_SPREAD: begin
                ov = s_q.busy && (s_q.pix_rem != '0) && (s_q.nbits >= NB_W'(PIX_W));
                od = s_q.phase ? word[WORD_W-1:BYTE_W] : word[BYTE_W-1:0];
                ol = s_q.phase && (s_q.pix_rem == CNT_W'(1));
            end
            default: begin
                ov = s_q.busy && (s_q.nbits >= NB_W'(BYTE_W));
                ol = (s_q.in_rem == '0);
            end
        endcase
        fire_out = ov && out_ready;

        // Drain the accumulator
        acc_a = s_q.acc;
        nb_a  = s_q.nbits;
        if (fire_out) begin
            if (s_q.mode == MODE_SPREAD) begin
                s_d.phase = !s_q.phase;
                if (s_q.phase) begin
                    acc_a       = s_q.acc >> PIX_W;
                    nb_a        = s_q.nbits - NB_W'(PIX_W);
                    s_d.pix_rem = s_q.pix_rem - 1'b1;
                end
            end else begin
                acc_a = s_q.acc >> BYTE_W;
                nb_a  = (s_q.nbits >= NB_W'(BYTE_W)) ? s_q.nbits - NB_W'(BYTE_W) : '0;
            end
        end

        // Input side: room is judged after this cycle's drain
        case (s_q.mode)
            MODE_PACK:
                ir = s_q.busy && (s_q.in_rem != '0) &&
                     (!s_q.half || nb_a <= NB_W'(ACC_W - PIX_W));
            MODE_SPREAD:
                ir = s_q.busy && (s_q.in_rem != '0) && (nb_a <= NB_W'(ACC_W - BYTE_W));
            default:
                ir = s_q.busy && (s_q.in_rem != '0) && (nb_a == '0);
        endcase
        fire_in = in_valid && ir;
        pix_new = {in_data[1:0], s_q.lo};

        if (fire_in) begin
            s_d.in_rem = s_q.in_rem - 1'b1;
            if (s_q.mode == MODE_PACK) begin
                if (!s_q.half) begin
                    s_d.half = 1'b1;
                    s_d.lo   = in_data;
                end else begin
                    acc_a    = acc_a | (ACC_W'(pix_new) << nb_a);
                    nb_a     = nb_a + NB_W'(PIX_W);
                    s_d.half = 1'b0;
                end
            end else begin
                acc_a = acc_a | (ACC_W'(in_data) << nb_a);
                nb_a  = nb_a + NB_W'(BYTE_W);
            end
        end
        s_d.acc   = acc_a;
        s_d.nbits = nb_a;

        // Line end: drop any residue so the next line starts at bit 0
        if (s_q.busy && s_q.in_rem == '0 &&
            ((s_q.mode == MODE_SPREAD) ? (s_q.pix_rem == '0) : (s_q.nbits == '0))) begin
            s_d.busy  = 1'b0;
            s_d.acc   = '0;
            s_d.nbits = '0;
            s_d.half  = 1'b0;
            s_d.phase = 1'b0;
        end

        if (launch) begin
            s_d.busy    = 1'b1;
            s_d.mode    = launch_mode;
            s_d.ofs     = launch_ofs;
            s_d.in_rem  = launch_len;
            s_d.pix_rem = launch_pix;
            s_d.acc     = '0;
            s_d.nbits   = '0;
            s_d.half    = 1'b0;
            s_d.phase   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign in_ready  = ir;
    assign out_valid = ov;
    assign out_data  = od;
    assign out_last  = ov && ol;
    assign busy      = s_q.busy;
endmodule

// File: rtl/raw10_repack.sv
module raw10_repack
    import raw10_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic [1:0]        bit_ofs,
    input  logic [CNT_W-1:0]  line_pix,
    input  logic              src_lsb,
    input  logic              dst_lsb,
    input  logic              err_clr,
    output logic              busy,
    output logic              align_err,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_last,
    input  logic              out_ready
);
    localparam int REM_W = CNT_W + 1;

    mode_e             mode_sel;
    logic              launch;
    logic [REM_W-1:0]  in_len;

    assign mode_sel = mode_e'(mode);

    raw10_launch u_launch (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mode      (mode_sel),
        .src_lsb   (src_lsb),
        .dst_lsb   (dst_lsb),
        .err_clr   (err_clr),
        .core_busy (busy),
        .launch    (launch),
        .align_err (align_err)
    );

    raw10_len_calc #(
        .CNT_W (CNT_W),
        .REM_W (REM_W)
    ) u_len (
        .mode   (mode_sel),
        .pix    (line_pix),
        .in_len (in_len)
    );

    raw10_repack_core #(
        .CNT_W (CNT_W),
        .REM_W (REM_W)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .launch_mode (mode_sel),
        .launch_ofs  (bit_ofs),
        .launch_pix  (line_pix),
        .launch_len  (in_len),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .in_ready    (in_ready),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .out_last    (out_last),
        .out_ready   (out_ready),
        .busy        (busy)
    );
endmodule

// File: rtl/raw10_repack_chk.sv
module raw10_repack_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       align_err,
    input logic       err_clr,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic       out_last,
    input logic [7:0] out_data
);
    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

    // R10
    idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !in_ready);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        align_err && !err_clr |=> align_err);

    // R7
    err_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        align_err && !busy |=> !busy);

    // R1
    valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);
endmodule

bind raw10_repack raw10_repack_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .align_err (align_err),
    .err_clr   (err_clr),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_last  (out_last),
    .out_data  (out_data)
);

// File: tb/raw10_repack_tb.sv
module raw10_repack_tb;
    localparam int CLK_P = 10;
    localparam int CNT_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [1:0]       mode = 2'd0;
    logic [1:0]       bit_ofs = 2'd0;
    logic [CNT_W-1:0] line_pix = '0;
    logic             src_lsb = 1'b0;
    logic             dst_lsb = 1'b0;
    logic             err_clr = 1'b0;
    logic             busy, align_err, in_ready, out_valid, out_last;
    logic [7:0]       out_data;
    logic             in_valid;
    logic [7:0]       in_data;
    logic             out_ready;

    int        n_chk = 0;
    int        n_fail = 0;
    logic [7:0] in_q[$];
    logic [8:0] exp_q[$];
    string     cur_req = "R1";
    logic      stall_en = 1'b0;
    logic      feed_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic      prev_stall = 1'b0;
    logic [8:0] prev_out = '0;
    logic [8:0] exp_item;

    always #(CLK_P/2) clk = ~clk;

    raw10_repack #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .bit_ofs(bit_ofs),
        .line_pix(line_pix), .src_lsb(src_lsb), .dst_lsb(dst_lsb), .err_clr(err_clr),
        .busy(busy), .align_err(align_err), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last), .out_ready(out_ready)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Driver of handshakes and scoreboard monitor in one process
    always @(negedge clk) begin
        lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = stall_en ? lfsr[0] : 1'b1;
        in_valid  = feed_en && (in_q.size() > 0) && (!stall_en || lfsr[3]);
        in_data   = (in_q.size() > 0) ? in_q[0] : 8'h00;
        #1;
        if (rst_n) begin
            if (prev_stall)
                chk(out_valid && ({out_last, out_data} == prev_out), "R9",
                    "held output", int'({out_valid, out_last, out_data}), int'({1'b1, prev_out}));
            prev_stall = out_valid && !out_ready;
            prev_out   = {out_last, out_data};
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, cur_req, "unexpected byte", int'({out_last, out_data}), 0);
                end else begin
                    exp_item = exp_q.pop_front();
                    chk({out_last, out_data} == exp_item, cur_req, "output byte",
                        int'({out_last, out_data}), int'(exp_item));
                end
            end
            if (in_valid && in_ready) void'(in_q.pop_front());
        end
    end

    task automatic run_line(input logic [1:0] m, input logic [1:0] o, input int n,
                            input int seed, input logic s_l, input logic d_l,
                            input string req);
        logic [9:0]  px[$];
        logic [7:0]  b;
        logic [15:0] w;
        int          nb;
        int          idx;
        cur_req = req;
        for (int i = 0; i < n; i++)
            px.push_back(i == 0 ? 10'h3FF : (i == 1 ? 10'h000 : 10'(i * 37 + seed * 101 + 5)));
        nb = (10 * n + 7) / 8;
        case (m)
            2'd1: begin
                for (int i = 0; i < n; i++) begin
                    in_q.push_back(px[i][7:0]);
                    in_q.push_back({6'(i * 13 + seed) | 6'h21, px[i][9:8]});
                end
                for (int j = 0; j < nb; j++) begin
                    for (int k = 0; k < 8; k++) begin
                        idx  = 8 * j + k;
                        b[k] = (idx < 10 * n) ? px[idx / 10][idx % 10] : 1'b0;
                    end
                    exp_q.push_back({j == nb - 1, b});
                end
            end
            2'd2: begin
                for (int j = 0; j < nb; j++) begin
                    for (int k = 0; k < 8; k++) begin
                        idx  = 8 * j + k;
                        b[k] = (idx < 10 * n) ? px[idx / 10][idx % 10] : 1'b1;
                    end
                    in_q.push_back(b);
                end
                for (int i = 0; i < n; i++) begin
                    w = 16'(px[i]) << (2 * o);
                    exp_q.push_back({1'b0, w[7:0]});
                    exp_q.push_back({i == n - 1, w[15:8]});
                end
            end
            default: begin
                for (int i = 0; i < n; i++) begin
                    in_q.push_back(px[i][7:0]);
                    exp_q.push_back({i == n - 1, px[i][7:0]});
                end
            end
        endcase
        mode = m; bit_ofs = o; line_pix = CNT_W'(n); src_lsb = s_l; dst_lsb = d_l;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (busy) @(negedge clk);
        chk(exp_q.size() == 0, req, "output bytes missing", exp_q.size(), 0);
        chk(in_q.size() == 0, req, "input bytes unconsumed", in_q.size(), 0);
        chk(align_err == 1'b0, req, "align_err", int'(align_err), 0);
        exp_q.delete();
        in_q.delete();
    endtask

    task automatic bad_start(input logic [1:0] m, input logic s_l, input logic d_l);
        mode = m; src_lsb = s_l; dst_lsb = d_l; line_pix = CNT_W'(4);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(align_err == 1'b1, "R7", "align_err after bad start", int'(align_err), 1);
        chk(busy == 1'b0, "R7", "busy after bad start", int'(busy), 0);
        // R8: an aligned start is ignored while the flag is set
        src_lsb = 1'b0; dst_lsb = 1'b0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R8", "busy while error set", int'(busy), 0);
        chk(out_valid == 1'b0, "R8", "out_valid while error set", int'(out_valid), 0);
        chk(align_err == 1'b1, "R8", "flag sticky", int'(align_err), 1);
        err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
        chk(align_err == 1'b0, "R8", "flag cleared", int'(align_err), 0);
    endtask

    initial begin
        feed_en = 1'b1;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && out_valid == 1'b0, "R10", "reset outputs",
            int'({busy, out_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b0, "R10", "in_ready idle", int'(in_ready), 0);
        chk(align_err == 1'b0, "R7", "align_err after reset", int'(align_err), 0);

        run_line(2'd0, 2'd0, 9, 1, 1'b1, 1'b1, "R1");
        run_line(2'd1, 2'd0, 4, 2, 1'b0, 1'b1, "R3");
        run_line(2'd1, 2'd0, 7, 3, 1'b0, 1'b0, "R4");
        run_line(2'd2, 2'd0, 5, 4, 1'b1, 1'b0, "R5");
        run_line(2'd2, 2'd1, 3, 5, 1'b0, 1'b0, "R5");
        run_line(2'd2, 2'd2, 6, 6, 1'b0, 1'b0, "R5");
        run_line(2'd2, 2'd3, 7, 7, 1'b0, 1'b0, "R5");
        run_line(2'd3, 2'd0, 5, 8, 1'b1, 1'b1, "R10");
        run_line(2'd1, 2'd0, 0, 9, 1'b0, 1'b0, "R11");
        run_line(2'd2, 2'd0, 0, 9, 1'b0, 1'b0, "R11");

        // R6: residue of one line must not leak into the next
        run_line(2'd1, 2'd0, 3, 10, 1'b0, 1'b0, "R6");
        run_line(2'd1, 2'd0, 5, 11, 1'b0, 1'b0, "R6");
        run_line(2'd2, 2'd1, 3, 12, 1'b0, 1'b0, "R6");
        run_line(2'd2, 2'd2, 2, 13, 1'b0, 1'b0, "R6");

        stall_en = 1'b1;
        run_line(2'd0, 2'd0, 20, 14, 1'b0, 1'b0, "R9");
        run_line(2'd1, 2'd0, 13, 15, 1'b0, 1'b0, "R2");
        run_line(2'd2, 2'd3, 11, 16, 1'b1, 1'b0, "R9");
        stall_en = 1'b0;

        bad_start(2'd1, 1'b1, 1'b0);
        bad_start(2'd2, 1'b0, 1'b1);
        run_line(2'd1, 2'd0, 4, 17, 1'b0, 1'b0, "R8");

        // R10: a start pulse during an active line changes nothing
        fork
            run_line(2'd1, 2'd0, 40, 18, 1'b0, 1'b0, "R10");
            begin
                repeat (4) @(negedge clk);
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        join

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "WD", "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule